// File: doc/BRIEF.md
# Frame Buffer Host Handshake Controller

This block guards a single-frame output buffer that sits between a processing engine, which writes finished pixels one word per cycle, and a host that reads the frame over its own bus. The buffer is made of several 16-bit memory banks (three banks of 32K words by default). The controller keeps the running word index. It turns each accepted write into a one-hot bank strobe plus an in-bank address, and it counts words until a whole frame (320 by 240 = 76,800 words by default) has been stored.

When the final word of a frame lands, the controller raises a level interrupt toward the host and drops its ready flag, which shuts off the writer. The buffer then stays frozen until the host pulses its acknowledge. The acknowledge drops the interrupt in that same cycle, clears the word index, and opens the buffer for the next frame. Any write attempted while the buffer is frozen is discarded and sets a sticky overrun flag.

Top module: `fbh_frame_buffer_ctrl`

## Requirements
- R1: While reset is low and after it is released, wr_ready is 1, host_irq is 0, overrun is 0, bank_we is 0 and bank_sel is all zero.
- R2: When wr_en is high and wr_ready is high, bank_we is 1 in that same cycle and bank_wdata equals wr_data. When wr_en is low, bank_we is 0.
- R3: For an accepted write, the word index is the number of writes accepted since the last reset or acknowledge. Bit (i >> BANK_AW) of bank_sel is the only bit set, so bank 0 holds the lowest indices, and bank_addr carries the low BANK_AW bits of the index. bank_sel is all zero in any cycle without an accepted write.
- R4: On the clock edge that accepts write number FRAME_WORDS, host_irq goes to 1 and wr_ready goes to 0.
- R5: Once host_irq is raised, it stays at 1 in every cycle until host_ack is high.
- R6: While the buffer is full, host_ack forces host_irq to 0 in the same cycle. wr_ready is 1 from the next cycle on, and the next accepted write uses index 0.
- R7: While the buffer is full, wr_en produces no bank_we and no bank_sel bit, and overrun becomes 1 on the following cycle. overrun stays at 1 until reset.
- R8: host_ack while the buffer is not full has no effect: host_irq stays 0 and the word index continues.
- R9: Cycles with wr_en low do not advance the word index.
- R10: When wr_en and host_ack are both high in a cycle where the buffer is full, the write is dropped and sets overrun, the interrupt clears, and the next accepted write uses index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writer presents a word this cycle |
| wr_data | input | DATA_W | Word from the writer |
| wr_ready | output | 1 | Buffer accepts writes (handshake flag) |
| bank_sel | output | NUM_BANKS | One-hot bank strobe for the current write |
| bank_we | output | 1 | Write enable toward the banks |
| bank_addr | output | BANK_AW | Address within the selected bank |
| bank_wdata | output | DATA_W | Data toward the banks |
| host_ack | input | 1 | Host has finished reading the frame |
| host_irq | output | 1 | Frame-complete interrupt level |
| overrun | output | 1 | Sticky flag: a write arrived while the buffer was full |

## Verification
Two functions can land in the same cycle. The first is a blocked write that must set overrun, and the second is the host acknowledge that reopens the buffer. The bench provokes this by raising wr_en and host_ack together while the buffer is full. It then checks that no bank strobe fires, that the interrupt drops within that cycle, that overrun is set on the next cycle, and that the following write goes to index 0. A second collision is an acknowledge that arrives while the frame is still being written. It is judged by checking that the index keeps counting and that no interrupt appears.

// File: rtl/fbh_pkg.sv
package fbh_pkg;

   typedef enum logic [1:0] {
      FBH_IDLE      = 2'd0,
      FBH_WRITING   = 2'd1,
      FBH_FULL_WAIT = 2'd2
   } fbh_state_t;

endpackage

// File: rtl/fbh_word_counter.sv
module fbh_word_counter #(
   parameter int ADDR_W      = 17,
   parameter int FRAME_WORDS = 76800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              clr,
   output logic [ADDR_W-1:0] count,
   output logic              last
);

   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(FRAME_WORDS - 1);

   logic [ADDR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != LAST_IDX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count = cnt_q;
   assign last  = (cnt_q == LAST_IDX);

endmodule

// File: rtl/fbh_bank_decode.sv
module fbh_bank_decode #(
   parameter int NUM_BANKS = 3,
   parameter int BANK_AW   = 15,
   parameter int ADDR_W    = 17
) (
   input  logic                 en,
   input  logic [ADDR_W-1:0]    index,
   output logic [NUM_BANKS-1:0] sel,
   output logic [BANK_AW-1:0]   offset
);

   localparam int BSEL_W = ADDR_W - BANK_AW;

   logic [BSEL_W-1:0] bank_idx;

   assign bank_idx = index[ADDR_W-1:BANK_AW];
   assign offset   = index[BANK_AW-1:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign sel[b] = en && (bank_idx == BSEL_W'(b));
   end

endmodule

// File: rtl/fbh_ctrl_fsm.sv
module fbh_ctrl_fsm
   import fbh_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic host_ack,
   input  logic last_word,
   output logic accept,
   output logic clr_cnt,
   output logic full,
   output logic overrun
);

   fbh_state_t state_q, state_d;
   logic       ovr_q;

   always_comb begin
      state_d = state_q;
      accept  = 1'b0;
      clr_cnt = 1'b0;
      unique case (state_q)
         FBH_IDLE, FBH_WRITING: begin
            accept = wr_en;
            if (wr_en) begin
               state_d = last_word ? FBH_FULL_WAIT : FBH_WRITING;
            end
         end
         FBH_FULL_WAIT: begin
            if (host_ack) begin
               clr_cnt = 1'b1;
               state_d = FBH_IDLE;
            end
         end
         default: state_d = FBH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FBH_IDLE;
         ovr_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if ((state_q == FBH_FULL_WAIT) && wr_en) begin
            ovr_q <= 1'b1;
         end
      end
   end

   assign full    = (state_q == FBH_FULL_WAIT);
   assign overrun = ovr_q;

endmodule

// File: rtl/fbh_frame_buffer_ctrl.sv
module fbh_frame_buffer_ctrl #(
   parameter int DATA_W      = 16,
   parameter int NUM_BANKS   = 3,
   parameter int BANK_AW     = 15,
   parameter int FRAME_WORDS = 76800
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   output logic                 wr_ready,
   output logic [NUM_BANKS-1:0] bank_sel,
   output logic                 bank_we,
   output logic [BANK_AW-1:0]   bank_addr,
   output logic [DATA_W-1:0]    bank_wdata,
   input  logic                 host_ack,
   output logic                 host_irq,
   output logic                 overrun
);

   localparam int CAPACITY = NUM_BANKS * (1 << BANK_AW);
   localparam int ADDR_W   = $clog2(CAPACITY);

   if (NUM_BANKS < 2) begin : g_chk_banks
      $error("fbh_frame_buffer_ctrl: NUM_BANKS must be at least 2");
   end
   if (FRAME_WORDS < 1 || FRAME_WORDS > CAPACITY) begin : g_chk_frame
      $error("fbh_frame_buffer_ctrl: FRAME_WORDS must fit the banks");
   end
   if (DATA_W < 1 || BANK_AW < 1) begin : g_chk_width
      $error("fbh_frame_buffer_ctrl: widths must be positive");
   end

   logic              accept;
   logic              clr_cnt;
   logic              full;
   logic              last_word;
   logic [ADDR_W-1:0] word_idx;

   fbh_ctrl_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .host_ack  (host_ack),
      .last_word (last_word),
      .accept    (accept),
      .clr_cnt   (clr_cnt),
      .full      (full),
      .overrun   (overrun)
   );

   fbh_word_counter #(
      .ADDR_W      (ADDR_W),
      .FRAME_WORDS (FRAME_WORDS)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (accept),
      .clr   (clr_cnt),
      .count (word_idx),
      .last  (last_word)
   );

   fbh_bank_decode #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_AW   (BANK_AW),
      .ADDR_W    (ADDR_W)
   ) u_dec (
      .en     (accept),
      .index  (word_idx),
      .sel    (bank_sel),
      .offset (bank_addr)
   );

   assign bank_we    = accept;
   assign bank_wdata = wr_data;
   assign wr_ready   = !full;
   assign host_irq   = full && !host_ack;

endmodule

// File: rtl/fbh_checker.sv
module fbh_checker #(
   parameter int NUM_BANKS = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic                 wr_ready,
   input logic [NUM_BANKS-1:0] bank_sel,
   input logic                 bank_we,
   input logic                 host_ack,
   input logic                 host_irq,
   input logic                 overrun
);

   assert_sel_onehot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_sel));

   assert_we_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |-> ($countones(bank_sel) == 1));

   assert_we_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |-> wr_en);

   assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ready |-> (!bank_we && (bank_sel == '0)));

   assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ready && wr_en) |=> overrun);

   assert_irq_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> !wr_ready);

   assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |=> (host_irq || host_ack));

   assert_ack_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |-> !host_irq);

   assert_ack_reopens_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ready && host_ack) |=> wr_ready);

endmodule

bind fbh_frame_buffer_ctrl fbh_checker #(
   .NUM_BANKS (NUM_BANKS)
) u_fbh_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_ready (wr_ready),
   .bank_sel (bank_sel),
   .bank_we  (bank_we),
   .host_ack (host_ack),
   .host_irq (host_irq),
   .overrun  (overrun)
);

// File: tb/fbh_frame_buffer_ctrl_bench.sv
module fbh_frame_buffer_ctrl_bench;

   localparam int DW  = 16;
   localparam int NB  = 3;
   localparam int BAW = 4;
   localparam int FW  = 40;
   localparam int NROWS = 12;

   // row = {wr_en, host_ack, cycle count}
   localparam logic [9:0] STIM [NROWS] = '{
      {1'b0, 1'b0, 8'd3},   // R9 idle
      {1'b0, 1'b1, 8'd2},   // R8 ack while empty
      {1'b1, 1'b0, 8'd10},  // R2 R3 writes into bank 0
      {1'b0, 1'b0, 8'd2},   // R9 gap
      {1'b1, 1'b1, 8'd3},   // R8 ack while writing
      {1'b1, 1'b0, 8'd27},  // R3 R4 cross banks and fill
      {1'b0, 1'b0, 8'd4},   // R5 hold interrupt
      {1'b1, 1'b0, 8'd2},   // R7 write while full
      {1'b0, 1'b1, 8'd1},   // R6 ack
      {1'b1, 1'b0, 8'd40},  // R4 second full frame
      {1'b1, 1'b1, 8'd1},   // R10 write and ack together
      {1'b1, 1'b0, 8'd5}    // R10 next frame restarts at 0
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          host_ack = 1'b0;
   logic          wr_ready;
   logic [NB-1:0] bank_sel;
   logic          bank_we;
   logic [BAW-1:0] bank_addr;
   logic [DW-1:0] bank_wdata;
   logic          host_irq;
   logic          overrun;

   int tests = 0;
   int fails = 0;
   int m_idx = 0;
   bit m_full = 1'b0;
   bit m_ovr = 1'b0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fbh_frame_buffer_ctrl #(
      .DATA_W      (DW),
      .NUM_BANKS   (NB),
      .BANK_AW     (BAW),
      .FRAME_WORDS (FW)
   ) u_fbh_frame_buffer_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .wr_ready   (wr_ready),
      .bank_sel   (bank_sel),
      .bank_we    (bank_we),
      .bank_addr  (bank_addr),
      .bank_wdata (bank_wdata),
      .host_ack   (host_ack),
      .host_irq   (host_irq),
      .overrun    (overrun)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // one cycle: drive at negedge, check just after, advance model
   task automatic step(input bit we_in, input bit ack_in);
      bit e_we;
      int e_sel;
      @(negedge clk);
      wr_en    = we_in;
      host_ack = ack_in;
      wr_data  = DW'(16'hA500 ^ (cyc * 16'h0137));
      cyc++;
      #1;
      e_we  = we_in && !m_full;
      e_sel = e_we ? (1 << (m_idx / (1 << BAW))) : 0;
      chk(wr_ready == !m_full, "R4", "wr_ready", int'(wr_ready), int'(!m_full));
      chk(host_irq == (m_full && !ack_in), "R5", "host_irq", int'(host_irq),
          int'(m_full && !ack_in));
      chk(overrun == m_ovr, "R7", "overrun", int'(overrun), int'(m_ovr));
      chk(bank_we == e_we, "R2", "bank_we", int'(bank_we), int'(e_we));
      chk(int'(bank_sel) == e_sel, "R3", "bank_sel", int'(bank_sel), e_sel);
      if (e_we) begin
         chk(int'(bank_addr) == (m_idx % (1 << BAW)), "R3", "bank_addr",
             int'(bank_addr), m_idx % (1 << BAW));
         chk(bank_wdata == wr_data, "R2", "bank_wdata", int'(bank_wdata),
             int'(wr_data));
      end
      if (m_full) begin
         if (we_in) m_ovr = 1'b1;
         if (ack_in) begin
            m_full = 1'b0;
            m_idx  = 0;
         end
      end else if (e_we) begin
         if (m_idx == FW - 1) m_full = 1'b1;
         else m_idx++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      // R1 during reset
      repeat (3) @(negedge clk);
      #1;
      chk(wr_ready == 1'b1, "R1", "wr_ready in reset", int'(wr_ready), 1);
      chk(host_irq == 1'b0, "R1", "host_irq in reset", int'(host_irq), 0);
      chk(overrun == 1'b0, "R1", "overrun in reset", int'(overrun), 0);
      chk(bank_sel == '0, "R1", "bank_sel in reset", int'(bank_sel), 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int r = 0; r < NROWS; r++) begin
         for (int k = 0; k < int'(STIM[r][7:0]); k++) begin
            step(STIM[r][9], STIM[r][8]);
         end
      end

      // R10 directed: fill, collide write with ack, check restart index
      while (!m_full) step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      chk(m_idx == 0, "R10", "model index", m_idx, 0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);

      // R6 ack on first full cycle, then R1 mid-run reset clears overrun
      while (!m_full) step(1'b1, 1'b0);
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      chk(wr_ready == 1'b1, "R6", "wr_ready after ack", int'(wr_ready), 1);
      step(1'b1, 1'b0);
      @(negedge clk);
      wr_en = 1'b0;
      host_ack = 1'b0;
      rst_n = 1'b0;
      #1;
      chk(overrun == 1'b0, "R1", "overrun after reset", int'(overrun), 0);
      chk(host_irq == 1'b0, "R1", "host_irq after reset", int'(host_irq), 0);
      chk(wr_ready == 1'b1, "R1", "wr_ready after reset", int'(wr_ready), 1);
      m_idx = 0;
      m_full = 1'b0;
      m_ovr = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 20; k++) step(1'b1, 1'b0);  // R3 bank 1 entry at 16
      step(1'b0, 1'b0);

      finish_run();
   end

endmodule